// File: doc/BRIEF.md
# Dual-Mode FIFO Write-Side Full / Ready Flag

This block produces the write-side status flag of a synchronous FIFO. It tracks how many words the FIFO holds from accepted write and read events and tells the writer when no room remains. It has two operating modes. In standard mode the flag is an active-low full indication. In first-word-fall-through mode the flag is an input-ready indication, low while space is free, and the occupancy also counts the word waiting in the output staging register, so the FIFO holds one word more before it refuses writes.

The flag leaves the block through a two-register pipeline on the write clock. A cascade select, used when several FIFOs are chained for depth expansion, inverts the standard-mode flag so that it can drive the neighbouring device directly. A single clock serves both the write and the read side; the block does no crossing between clock domains. A write-accept strobe shows, in the same cycle, whether the current write request is taken.

Top module: `fifo_wr_flag`

## Requirements
- R1: In standard mode (`fwft_mode`=0, `cascade_sel`=0) the flag is 0 when occupancy equals DEPTH and 1 otherwise.
- R2: In fall-through mode (`fwft_mode`=1) the flag is 1 when occupancy equals DEPTH+1 and 0 otherwise; `cascade_sel` has no effect in this mode.
- R3: Capacity is DEPTH words in standard mode and DEPTH+1 words in fall-through mode, so the no-room state takes one more write in fall-through mode.
- R4: A write request while the FIFO has no room and no read is accepted in the same cycle is ignored: `wr_accept` is 0 and occupancy does not change.
- R5: A read and a write in the same cycle while the FIFO is full are both taken: occupancy stays at capacity and the flag stays in its no-room state.
- R6: A read request while occupancy is zero is ignored and occupancy stays at zero.
- R7: The flag reflects the occupancy after a clock edge two rising edges later (two register stages).
- R8: In standard mode with `cascade_sel`=1 the flag is inverted: 1 when full, 0 otherwise.
- R9: Synchronous active-low reset clears occupancy to zero and loads both flag stages with the empty-state value of the current mode.
- R10: `wr_accept` is 1 exactly when `wr_req` is 1 and either room remains or a read is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock (single clock for both sides) |
| rst_n | input | 1 | Synchronous active-low reset |
| fwft_mode | input | 1 | 1 selects fall-through mode, 0 standard mode; change only in reset |
| cascade_sel | input | 1 | Inverts the standard-mode flag for depth cascading; change only in reset |
| wr_req | input | 1 | Write request for this cycle |
| rd_req | input | 1 | Read request for this cycle |
| flag_o | output | 1 | Full flag (standard) or input-ready (fall-through), two stages late |
| wr_accept | output | 1 | Current write request is taken |

## Verification
The bench fills the FIFO to exactly its capacity in each mode and checks that the fall-through mode needs the extra write; a design that ignored the staging word would report no room one write early. It keeps writing past capacity and then drains, so a counter that wrapped or took blocked writes would leave the flag wrong while draining. It issues a read with a write while full, where a design that blocked the write would drop to one below capacity, and reads while empty, where a counter that underflowed would show full. Every cycle is compared against a model with a two-edge delay, so an off-by-one stage count or a wrong reset polarity under the cascade select shows at once.

// File: rtl/fifo_flag_pkg.sv
// Shared helpers for the FIFO write-side flag block.
// Assumes: one clock; mode inputs are stable outside reset.
package fifo_flag_pkg;

    // Map the internal "no room" condition to the pin level for the mode.
    function automatic logic flag_level(input logic no_room,
                                        input logic fwft,
                                        input logic cascade);
        logic active_low;
        active_low = ~fwft & ~cascade;
        return no_room ^ active_low;
    endfunction

endpackage

// File: rtl/fifo_occ_counter.sv
// Occupancy counter for the FIFO write-side flag.
// Counts accepted writes minus accepted reads. Capacity is DEPTH, or
// DEPTH+1 in fall-through mode where the output staging word counts.
// Assumes fwft_mode is stable outside reset.
module fifo_occ_counter #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic [CW-1:0] occ,
    output logic          no_room,
    output logic          wr_ok
);

    localparam logic [CW-1:0] CAP_STD  = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_FWFT = CW'(DEPTH + 1);

    logic [CW-1:0] cap;
    logic          rd_ok;

    // Select the capacity and decide which requests are taken this cycle.
    always_comb begin
        cap     = fwft_mode ? CAP_FWFT : CAP_STD;
        no_room = (occ == cap);
        rd_ok   = rd_req && (occ != '0);
        wr_ok   = wr_req && (!no_room || rd_ok);
    end

    // Update occupancy from the accepted events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ <= '0;
        else if (wr_ok && !rd_ok)
            occ <= occ + 1'b1;
        else if (rd_ok && !wr_ok)
            occ <= occ - 1'b1;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= cap);

    // R4
    blocked_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_room && wr_req && !rd_req) |=> (occ == $past(occ)));

    // R5
    full_rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_room && wr_req && rd_req) |=> (occ == cap));

    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && rd_req && !wr_req) |=> (occ == '0));

endmodule

// File: rtl/fifo_flag_pipe.sv
// Register pipeline for the flag on the write clock.
// STAGES registers in series; each resets to rst_val.
// Assumes STAGES >= 1.
module fifo_flag_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_val,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stg;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            logic src;
            if (i == 0) begin : g_first
                assign src = d;
            end else begin : g_next
                assign src = stg[i-1];
            end
            // Shift the flag one stage per write-clock edge.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[i] <= rst_val;
                else
                    stg[i] <= src;
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/fifo_wr_flag.sv
// Write-side full / input-ready flag generator for a synchronous FIFO.
// Standard mode: active-low full (inverted when cascade_sel is set).
// Fall-through mode: input-ready, high when no room, capacity DEPTH+1.
// Assumes a single clock and mode inputs changed only during reset.
module fifo_wr_flag
    import fifo_flag_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int FLAG_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fwft_mode,
    input  logic cascade_sel,
    input  logic wr_req,
    input  logic rd_req,
    output logic flag_o,
    output logic wr_accept
);

    localparam int CW = $clog2(DEPTH + 2);

    logic [CW-1:0] occ;
    logic          no_room;
    logic          raw_level;
    logic          empty_level;

    fifo_occ_counter #(.DEPTH(DEPTH), .CW(CW)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwft_mode (fwft_mode),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .occ       (occ),
        .no_room   (no_room),
        .wr_ok     (wr_accept)
    );

    // Pin level for the current state and for the empty state.
    always_comb begin
        raw_level   = flag_level(no_room, fwft_mode, cascade_sel);
        empty_level = flag_level(1'b0, fwft_mode, cascade_sel);
    end

    fifo_flag_pipe #(.STAGES(FLAG_STAGES)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (empty_level),
        .d       (raw_level),
        .q       (flag_o)
    );

    // R9
    reset_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (flag_o == empty_level));

    generate
        if (FLAG_STAGES == 2) begin : g_lat_chk
            // R7
            flag_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n, 1) && $past(rst_n, 2)) |-> (flag_o == $past(raw_level, 2)));
        end
    endgenerate

endmodule

// File: tb/tb_fifo_wr_flag.sv
module tb_fifo_wr_flag;

    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n, fwft_mode, cascade_sel, wr_req, rd_req;
    logic flag_o, wr_accept;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int occ_m   = 0;
    bit hist[$];
    string tag = "R9";

    fifo_wr_flag #(.DEPTH(DEPTH), .FLAG_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode), .cascade_sel(cascade_sel),
        .wr_req(wr_req), .rd_req(rd_req), .flag_o(flag_o), .wr_accept(wr_accept)
    );

    always #10 clk = ~clk;

    function automatic int cap_m();
        return fwft_mode ? DEPTH + 1 : DEPTH;
    endfunction

    function automatic bit pin_m(input int occ);
        bit full = (occ == cap_m());
        if (fwft_mode) return full;
        return cascade_sel ? full : ~full;
    endfunction

    task automatic check(input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0b exp=%0b (occ model %0d)", tag, what, act, exp, occ_m);
        end
    endtask

    // One cycle: drive at negedge, check accept, clock, update model, check flag.
    task automatic step(input bit wr, input bit rd);
        bit full, rok, wok;
        wr_req = wr; rd_req = rd;
        #1;
        full = (occ_m == cap_m());
        rok  = rd && (occ_m != 0);
        wok  = wr && (!full || rok);
        check("wr_accept (R10)", wr_accept, wok);
        @(posedge clk);
        if (rst_n) begin
            occ_m = occ_m + (wok ? 1 : 0) - (rok ? 1 : 0);
            hist.push_back(pin_m(occ_m));
        end
        @(negedge clk);
        check("flag (R7)", flag_o, hist[hist.size()-3]);
    endtask

    task automatic do_reset(input bit fw, input bit cas);
        rst_n = 1'b0; fwft_mode = fw; cascade_sel = cas; wr_req = 0; rd_req = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        occ_m = 0;
        hist.delete();
        repeat (3) hist.push_back(pin_m(0));
        tag = "R9";
        check("flag after reset", flag_o, pin_m(0));
        rst_n = 1'b1;
    endtask

    task automatic scenario(input bit fw, input bit cas);
        int capn;
        do_reset(fw, cas);
        capn = fw ? DEPTH + 1 : DEPTH;
        tag = fw ? "R2" : (cas ? "R8" : "R1");
        for (int i = 0; i < capn; i++) step(1, 0);
        step(0, 0); step(0, 0);
        tag = "R3";
        check("no-room level at capacity", flag_o, fw ? 1'b1 : cas);
        tag = "R4";
        for (int i = 0; i < 3; i++) step(1, 0);
        tag = "R5";
        step(1, 1); step(1, 1); step(0, 0);
        check("flag held full on read+write", flag_o, fw ? 1'b1 : cas);
        tag = "R4";
        step(0, 1); step(0, 0); step(0, 0);
        check("one read after blocked writes frees room", flag_o, fw ? 1'b0 : ~cas);
        tag = fw ? "R2" : "R1";
        for (int i = 0; i < capn; i++) step(0, 1);
        tag = "R6";
        for (int i = 0; i < 3; i++) step(0, 1);
        tag = "R3";
        for (int i = 0; i < capn - 1; i++) step(1, 0);
        step(0, 0); step(0, 0);
        check("one below capacity is not full", flag_o, fw ? 1'b0 : ~cas);
        tag = "R10";
        step(1, 0); step(1, 1); step(0, 1); step(1, 0); step(0, 0); step(0, 0);
    endtask

    initial begin
        rst_n = 0; fwft_mode = 0; cascade_sel = 0; wr_req = 0; rd_req = 0;
        @(negedge clk);
        scenario(0, 0);
        scenario(0, 1);
        scenario(1, 0);
        scenario(1, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp<=20000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule